// File: doc/BRIEF.md
# March C- Memory Test Engine

This engine tests a synchronous single-port RAM with `ADDR_W` address bits and `DATA_W` data bits. After a start pulse it drives the RAM port itself. It issues one operation per clock cycle, and each operation is a write of an all-zero or all-one background word or a read. The engine compares every read word with the background that a fault-free memory would hold at that point.

The run is made of six march elements, and each element sweeps the whole address space. Two of the read-then-write elements sweep downward, and this catches faults that depend on access order. The first read mismatch is captured together with its address and the index of the element it occurred in. A parameter selects what happens next: the engine either stops at once or finishes the full sweep. In both cases `done` rises at the end and stays high until the next accepted start.

Top module: `march_engine`

## Requirements
- R1: While `rst` is high and after it is released, `done`, `fail` and `mem_en` are 0.
- R2: An accepted run issues exactly 10·2^ADDR_W operations, in element order 0 to 5. The elements are:
  - 0: ascending, write zeros.
  - 1: ascending, read expecting zeros then write ones.
  - 2: ascending, read expecting ones then write zeros.
  - 3: descending (from address 2^ADDR_W-1 down to 0), read expecting zeros then write ones.
  - 4: descending, read expecting ones then write zeros.
  - 5: ascending, read expecting zeros.
- R3: One operation is issued per cycle. The write of a read-then-write pair uses the same address as the read and follows it in the next cycle. With a full run, `done` is first seen high 10·2^ADDR_W+1 cycles after the cycle in which `start` is sampled.
- R4: Every write carries either all zeros or all ones. After a fault-free run, every RAM word is zero.
- R5: A read issued in one cycle is compared in the next cycle, because the RAM has one cycle of read latency. A fault-free RAM leaves `fail` at 0.
- R6: On the first mismatch, `fail` goes to 1 and the engine captures `fail_addr` and `fail_elem` (the element index 0 to 5 from R2). Later mismatches in the same run do not change them.
- R7: With `STOP_ON_FAIL`=1, the engine issues no operation after the one on the port during the cycle in which the first mismatch is compared, and it raises `done` at that edge. With `STOP_ON_FAIL`=0, the full sequence of R2 runs regardless of mismatches.
- R8: `done`, `fail`, `fail_addr` and `fail_elem` hold their values until the next accepted start. An accepted start clears `done` and `fail`.
- R9: `start` is ignored while a run or its final compare is in progress.
- R10: `mem_we` is high only together with `mem_en`. The port is idle (`mem_en`=0) whenever `done` is high and before the first run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| done | output | 1 | Run finished (held) |
| fail | output | 1 | A mismatch was seen in the last run |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 3 | Element index (0 to 5) of the first mismatch |
| mem_en | output | 1 | RAM access this cycle |
| mem_we | output | 1 | RAM write (read when low and `mem_en` high) |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid the cycle after a read |

## Verification
The bound checker watches the rules that hold on every cycle:
- writes occur only with an enable and carry a uniform background;
- a write that follows a read uses the read's address;
- the port stays quiet while `done` is high;
- the failure record and `done` stay stable until a new start.

The properties that depend on a whole run can only be shown by the bench scenarios. These cover the exact element order and address direction, the total operation count and completion latency, and which address and element a given stuck bit or aliasing fault is reported against. They also cover the early stop count, the rejection of a start during a run, and the memory contents left behind.

// File: rtl/march_pkg.sv
package march_pkg;

  typedef enum logic [2:0] {
    EL_INIT_W0 = 3'd0,
    EL_UP_R0W1 = 3'd1,
    EL_UP_R1W0 = 3'd2,
    EL_DN_R0W1 = 3'd3,
    EL_DN_R1W0 = 3'd4,
    EL_UP_R0   = 3'd5
  } elem_e;

  // element has a read operation
  function automatic logic el_reads(elem_e e);
    return (e != EL_INIT_W0);
  endfunction

  // element has a write operation
  function automatic logic el_writes(elem_e e);
    return (e != EL_UP_R0);
  endfunction

  // element sweeps from the top address down
  function automatic logic el_down(elem_e e);
    return (e == EL_DN_R0W1) || (e == EL_DN_R1W0);
  endfunction

  // background bit expected by the read of the element
  function automatic logic el_rd_val(elem_e e);
    return (e == EL_UP_R1W0) || (e == EL_DN_R1W0);
  endfunction

  // background bit written by the element
  function automatic logic el_wr_val(elem_e e);
    return (e == EL_UP_R0W1) || (e == EL_DN_R0W1);
  endfunction

  function automatic elem_e el_next(elem_e e);
    case (e)
      EL_INIT_W0: return EL_UP_R0W1;
      EL_UP_R0W1: return EL_UP_R1W0;
      EL_UP_R1W0: return EL_DN_R0W1;
      EL_DN_R0W1: return EL_DN_R1W0;
      EL_DN_R1W0: return EL_UP_R0;
      default:    return EL_UP_R0;
    endcase
  endfunction

endpackage

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              abort,
  output logic              active,
  output logic [ADDR_W-1:0] op_addr,
  output logic              op_we,
  output logic [DATA_W-1:0] op_wdata,
  output logic              op_rd,
  output logic              op_rd_val,
  output elem_e             op_elem,
  output logic              op_last
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

  logic              ph_q;      // 0: read slot, 1: write slot of a pair
  logic              cur_pair;
  logic              cur_end;
  logic              n_active;
  elem_e             n_elem;
  logic [ADDR_W-1:0] n_addr;
  logic              n_ph;
  logic              n_is_wr;

  always_comb begin
    cur_pair = el_reads(op_elem) && el_writes(op_elem);
    cur_end  = el_down(op_elem) ? (op_addr == '0) : (op_addr == ADDR_TOP);
    n_active = active;
    n_elem   = op_elem;
    n_addr   = op_addr;
    n_ph     = ph_q;
    if (go) begin
      n_active = 1'b1;
      n_elem   = EL_INIT_W0;
      n_addr   = '0;
      n_ph     = 1'b0;
    end else if (active) begin
      if (abort) begin
        n_active = 1'b0;
      end else if (cur_pair && !ph_q) begin
        n_ph = 1'b1;
      end else begin
        n_ph = 1'b0;
        if (!cur_end) begin
          n_addr = el_down(op_elem) ? op_addr - 1'b1 : op_addr + 1'b1;
        end else if (op_elem == EL_UP_R0) begin
          n_active = 1'b0;
        end else begin
          n_elem = el_next(op_elem);
          n_addr = el_down(el_next(op_elem)) ? ADDR_TOP : '0;
        end
      end
    end
    n_is_wr = el_writes(n_elem) && (!el_reads(n_elem) || n_ph);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      op_elem   <= EL_INIT_W0;
      op_addr   <= '0;
      ph_q      <= 1'b0;
      op_we     <= 1'b0;
      op_wdata  <= '0;
      op_rd     <= 1'b0;
      op_rd_val <= 1'b0;
      op_last   <= 1'b0;
    end else begin
      active    <= n_active;
      op_elem   <= n_elem;
      op_addr   <= n_addr;
      ph_q      <= n_ph;
      op_we     <= n_active && n_is_wr;
      op_wdata  <= {DATA_W{el_wr_val(n_elem)}};
      op_rd     <= n_active && !n_is_wr;
      op_rd_val <= el_rd_val(n_elem);
      op_last   <= n_active && (n_elem == EL_UP_R0) && (n_addr == ADDR_TOP);
    end
  end

endmodule

// File: rtl/march_cmp.sv
module march_cmp
  import march_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 32,
  parameter bit STOP_ON_FAIL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              op_rd,
  input  logic              op_rd_val,
  input  elem_e             op_elem,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_last,
  input  logic [DATA_W-1:0] rd_data,
  output logic              pend,
  output logic              abort,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [2:0]        fail_elem,
  output logic              done
);

  logic              exp_q;
  logic [2:0]        elem_q;
  logic [ADDR_W-1:0] addr_q;
  logic              last_q;
  logic              mism;
  logic              first_hit;

  assign mism      = pend && (rd_data != {DATA_W{exp_q}});
  assign first_hit = mism && !fail;

  generate
    if (STOP_ON_FAIL) begin : g_stop
      assign abort = first_hit;
    end else begin : g_run_on
      assign abort = 1'b0;
    end
  endgenerate

  // read tag pipeline: aligned with the RAM's one-cycle read latency
  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      exp_q  <= 1'b0;
      elem_q <= '0;
      addr_q <= '0;
      last_q <= 1'b0;
    end else begin
      pend   <= op_rd;
      exp_q  <= op_rd_val;
      elem_q <= op_elem;
      addr_q <= op_addr;
      last_q <= op_last;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_elem <= '0;
      done      <= 1'b0;
    end else if (go) begin
      fail <= 1'b0;
      done <= 1'b0;
    end else begin
      if (first_hit) begin
        fail      <= 1'b1;
        fail_addr <= addr_q;
        fail_elem <= elem_q;
      end
      if ((pend && last_q) || abort) begin
        done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/march_engine.sv
module march_engine
  import march_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 32,
  parameter bit STOP_ON_FAIL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [2:0]        fail_elem,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic  go;
  logic  abort;
  logic  pend;
  logic  op_rd;
  logic  op_rd_val;
  logic  op_last;
  elem_e op_elem;

  // a start is taken only when neither operations nor a compare are in flight
  assign go = start && !mem_en && !pend;

  march_seq #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .abort    (abort),
    .active   (mem_en),
    .op_addr  (mem_addr),
    .op_we    (mem_we),
    .op_wdata (mem_wdata),
    .op_rd    (op_rd),
    .op_rd_val(op_rd_val),
    .op_elem  (op_elem),
    .op_last  (op_last)
  );

  march_cmp #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .STOP_ON_FAIL(STOP_ON_FAIL)
  ) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .op_rd    (op_rd),
    .op_rd_val(op_rd_val),
    .op_elem  (op_elem),
    .op_addr  (mem_addr),
    .op_last  (op_last),
    .rd_data  (mem_rdata),
    .pend     (pend),
    .abort    (abort),
    .fail     (fail),
    .fail_addr(fail_addr),
    .fail_elem(fail_elem),
    .done     (done)
  );

endmodule

// File: rtl/march_engine_chk.sv
module march_engine_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [2:0]        fail_elem,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);

  assert_we_needs_en_R10: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);

  assert_port_quiet_done_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_en);

  assert_background_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == {DATA_W{1'b0}} || mem_wdata == {DATA_W{1'b1}}));

  assert_pair_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |=> (!mem_we || mem_addr == $past(mem_addr)));

  assert_fail_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> fail);

  assert_fail_info_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> ($stable(fail_addr) && $stable(fail_elem)));

  assert_fail_elem_range_R6: assert property (@(posedge clk) disable iff (rst)
    fail |-> (fail_elem <= 3'd5));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

endmodule

bind march_engine march_engine_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .done     (done),
  .fail     (fail),
  .fail_addr(fail_addr),
  .fail_elem(fail_elem),
  .mem_en   (mem_en),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata)
);

// File: tb/march_engine_tb.sv
module march_engine_tb_ram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          fill,
  input  logic [DW-1:0] fill_val,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] f1_addr,
  input  logic [DW-1:0] f1_sa0,
  input  logic [DW-1:0] f1_sa1,
  input  logic [AW-1:0] f2_addr,
  input  logic [DW-1:0] f2_sa0,
  input  logic [DW-1:0] f2_sa1,
  input  logic          al_en,
  input  logic [AW-1:0] al_vic,
  input  logic [AW-1:0] al_agg
);
  logic [DW-1:0] mem [1<<AW];

  function automatic logic [DW-1:0] apply_faults(logic [AW-1:0] a, logic [DW-1:0] d);
    logic [DW-1:0] r;
    r = d;
    if (a == f1_addr) r = (r | f1_sa1) & ~f1_sa0;
    if (a == f2_addr) r = (r | f2_sa1) & ~f2_sa0;
    return r;
  endfunction

  always @(posedge clk) begin
    if (fill) begin
      for (int i = 0; i < (1<<AW); i++) mem[i] <= fill_val;
    end else if (en) begin
      if (we) begin
        mem[addr] <= apply_faults(addr, wdata);
        if (al_en && addr == al_agg) mem[al_vic] <= apply_faults(al_vic, wdata);
      end else begin
        rdata <= apply_faults(addr, mem[addr]);
      end
    end
  end
endmodule

module march_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int S  = 1 << AW;
  localparam int T  = 10 * S;
  localparam int LIMIT = T + 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic start_a = 1'b0, start_b = 1'b0;
  logic done_a, fail_a, en_a, we_a;
  logic done_b, fail_b, en_b, we_b;
  logic [AW-1:0] fail_addr_a, addr_a, fail_addr_b, addr_b;
  logic [2:0] fail_elem_a, fail_elem_b;
  logic [DW-1:0] wdata_a, rdata_a, wdata_b, rdata_b;

  logic          fill = 1'b0;
  logic [AW-1:0] f1_addr = '0, f2_addr = '0, al_vic = '0, al_agg = '0;
  logic [DW-1:0] f1_sa0 = '0, f1_sa1 = '0, f2_sa0 = '0, f2_sa1 = '0;
  logic          al_en = 1'b0;

  march_engine #(.ADDR_W(AW), .DATA_W(DW), .STOP_ON_FAIL(1'b0)) u_dut (
    .clk(clk), .rst(rst), .start(start_a), .done(done_a), .fail(fail_a),
    .fail_addr(fail_addr_a), .fail_elem(fail_elem_a), .mem_en(en_a), .mem_we(we_a),
    .mem_addr(addr_a), .mem_wdata(wdata_a), .mem_rdata(rdata_a));

  march_engine #(.ADDR_W(AW), .DATA_W(DW), .STOP_ON_FAIL(1'b1)) u_dut_stop (
    .clk(clk), .rst(rst), .start(start_b), .done(done_b), .fail(fail_b),
    .fail_addr(fail_addr_b), .fail_elem(fail_elem_b), .mem_en(en_b), .mem_we(we_b),
    .mem_addr(addr_b), .mem_wdata(wdata_b), .mem_rdata(rdata_b));

  march_engine_tb_ram #(.AW(AW), .DW(DW)) u_ram_a (
    .clk(clk), .fill(fill), .fill_val(8'hA5), .en(en_a), .we(we_a), .addr(addr_a),
    .wdata(wdata_a), .rdata(rdata_a), .f1_addr(f1_addr), .f1_sa0(f1_sa0), .f1_sa1(f1_sa1),
    .f2_addr(f2_addr), .f2_sa0(f2_sa0), .f2_sa1(f2_sa1), .al_en(al_en), .al_vic(al_vic),
    .al_agg(al_agg));

  march_engine_tb_ram #(.AW(AW), .DW(DW)) u_ram_b (
    .clk(clk), .fill(fill), .fill_val(8'hA5), .en(en_b), .we(we_b), .addr(addr_b),
    .wdata(wdata_b), .rdata(rdata_b), .f1_addr(f1_addr), .f1_sa0(f1_sa0), .f1_sa1(f1_sa1),
    .f2_addr(f2_addr), .f2_sa0(f2_sa0), .f2_sa1(f2_sa1), .al_en(al_en), .al_vic(al_vic),
    .al_agg(al_agg));

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // free-running port monitors (single writer each)
  int ops_a = 0, wr_a = 0, rd_a = 0, seq_err = 0, base_a = 0, ops_b = 0;

  // expected operation k of a run, derived from the element list of R2
  function automatic void exp_op(input int k, output bit we, output int a, output bit v);
    int j, e, r, ai;
    if (k < S) begin
      we = 1'b1; a = k; v = 1'b0;
    end else if (k < 9*S) begin
      j = k - S; e = j / (2*S) + 1; r = j % (2*S); ai = r / 2;
      a  = (e >= 3) ? (S - 1 - ai) : ai;
      we = (r % 2) == 1;
      v  = (e == 1) || (e == 3);
    end else begin
      we = 1'b0; a = k - 9*S; v = 1'b0;
    end
  endfunction

  always @(negedge clk) begin
    if (en_a) begin
      bit ew; int ea; bit ev;
      exp_op(ops_a - base_a, ew, ea, ev);
      if (ew != we_a || ea != int'(addr_a) || (ew && wdata_a != {DW{ev}})) seq_err++;
      if (we_a) wr_a++; else rd_a++;
      ops_a++;
    end
    if (en_b) ops_b++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic prep();
    @(negedge clk);
    f1_addr = '0; f1_sa0 = '0; f1_sa1 = '0;
    f2_addr = '0; f2_sa0 = '0; f2_sa1 = '0;
    al_en = 1'b0; al_vic = '0; al_agg = '0;
    fill = 1'b1;
    @(negedge clk);
    fill = 1'b0;
  endtask

  // n counts edges from the start-sampling edge (n=1) to the first done sighting
  task automatic kick(input bit which, input int poke, output int n);
    @(negedge clk);
    if (!which) begin base_a = ops_a; start_a = 1'b1; end
    else start_b = 1'b1;
    n = 0;
    do begin
      @(posedge clk); #1;
      start_a = 1'b0; start_b = 1'b0;
      n++;
      @(negedge clk);
      if (n == poke) begin
        if (!which) start_a = 1'b1; else start_b = 1'b1;
      end
    end while (!(which ? done_b : done_a) && n < LIMIT);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "done after reset", int'(done_a), 0);
    chk("R1", "fail after reset", int'(fail_a), 0);
    chk("R1", "mem_en after reset", int'(en_a), 0);
    chk("R1", "stop-variant done after reset", int'(done_b), 0);
    repeat (4) @(negedge clk);
    chk("R10", "no port activity while idle", ops_a + ops_b, 0);
  endtask

  task automatic t_clean();
    int n, s0, w0, r0, o0, nz;
    prep();
    s0 = seq_err; w0 = wr_a; r0 = rd_a; o0 = ops_a;
    kick(1'b0, 0, n);
    chk("R3", "completion latency", n, T + 2);
    chk("R2", "sequence mismatches", seq_err - s0, 0);
    chk("R2", "operation count", ops_a - o0, T);
    chk("R3", "write count", wr_a - w0, 5*S);
    chk("R3", "read count", rd_a - r0, 5*S);
    chk("R5", "fail on clean RAM", int'(fail_a), 0);
    nz = 0;
    for (int i = 0; i < S; i++) if (u_ram_a.mem[i] != '0) nz++;
    chk("R4", "nonzero words after run", nz, 0);
    o0 = ops_a;
    repeat (5) @(negedge clk);
    chk("R8", "done held", int'(done_a), 1);
    chk("R10", "port quiet after done", ops_a - o0, 0);
  endtask

  task automatic t_fault(input string req, input int ea, input int ee);
    int n;
    kick(1'b0, 0, n);
    chk(req, "fail flag", int'(fail_a), 1);
    chk(req, "fail address", int'(fail_addr_a), ea);
    chk(req, "fail element", int'(fail_elem_a), ee);
    chk("R7", "full run despite mismatch", n, T + 2);
  endtask

  task automatic t_sa1();
    prep();
    f1_addr = 4'd9; f1_sa1 = 8'h01;
    t_fault("R6", 9, 1);
  endtask

  task automatic t_sa0_top();
    prep();
    f1_addr = 4'(S-1); f1_sa0 = 8'h80;
    t_fault("R5", S-1, 2);
  endtask

  task automatic t_first_only();
    prep();
    f1_addr = 4'd9; f1_sa1 = 8'h10;
    f2_addr = 4'd3; f2_sa0 = 8'h02;
    t_fault("R6", 9, 1);
  endtask

  task automatic t_alias_down();
    prep();
    al_en = 1'b1; al_vic = 4'd2; al_agg = 4'd12;
    t_fault("R2", 2, 3);
  endtask

  task automatic t_stop();
    int n, o0;
    prep();
    f1_addr = 4'd9; f1_sa1 = 8'h04;
    o0 = ops_b;
    kick(1'b1, 0, n);
    chk("R7", "stop latency", n, 37);
    chk("R7", "operations before stop", ops_b - o0, S + 2*9 + 2);
    chk("R7", "stop fail flag", int'(fail_b), 1);
    chk("R7", "stop fail address", int'(fail_addr_b), 9);
    chk("R7", "stop fail element", int'(fail_elem_b), 1);
    o0 = ops_b;
    repeat (5) @(negedge clk);
    chk("R7", "no operations after stop", ops_b - o0, 0);
  endtask

  task automatic t_restart();
    int n, s0;
    prep();
    s0 = seq_err;
    kick(1'b0, 40, n);
    chk("R9", "latency with start mid-run", n, T + 2);
    chk("R9", "sequence undisturbed", seq_err - s0, 0);
    chk("R8", "fail cleared by new run", int'(fail_a), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_clean();
    t_sa1();
    t_sa0_top();
    t_first_only();
    t_restart();
    t_alias_down();
    t_stop();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule